// File: doc/BRIEF.md
# Floating-Point Status Register with Compare History Queue

This block holds the 32-bit status and control word that sits beside a floating-point datapath. It exposes the rounding-mode and flush-to-zero controls that the datapath reads, collects the five exception flags that each completed operation reports into sticky bits, and raises a one-cycle assist trap when a flag raised in that cycle is enabled.

Compare results also come back into this register. Each result arrives as a two-bit relation code, a five-bit condition mask and a four-bit target index. The mask picks one bit from the relation, and that bit is the compare outcome. A nonzero target writes the outcome into one addressed condition bit. A zero target pushes the outcome into the primary condition bit and shifts the previous primary bit down a ten-entry history queue. Software may load the whole word at any time, and such a load takes priority over any hardware update in the same cycle.

Top module: `fpsr_cq_top`

## Requirements
- R1: While reset is held and after its release, until the first update, `status_o` reads 0 and `assist_trap` is low.
- R2: `round_mode` equals status bits 10:9 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and `flush_zero` equals status bit 5.
- R3: When `op_valid` is high, `op_flags` (bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into status bits 31:27, with flag bit i landing in status bit 27+i. Set bits are never cleared by hardware.
- R4: `assist_trap` is high for exactly the cycle after an update in which the flags raised in that cycle AND status bits 4:0 (the enables, as held before the update) is nonzero.
- R5: The compare outcome is a bit of `cmp_mask` chosen by `cmp_rel`: code 0 (greater) picks mask bit 4, code 1 (less) picks bit 3, code 2 (equal) picks bit 2, and code 3 (unordered) picks bit 1.
- R6: With `cmp_target` y in 1..10, only status bit 22-y receives the compare outcome.
- R7: With `cmp_target` 0, status bits 20:11 take the old bits 21:12, bit 21 takes the old bit 26, and bit 26 takes the new outcome.
- R8: When `cmp_mask` bit 0 is set (signaling compare) and the relation is unordered, the invalid flag (status bit 31) is raised and takes part in the trap check of R4.
- R9: A cycle with `sw_we` high loads `sw_wdata` unchanged, ignores any operation or compare in that cycle, and leaves `assist_trap` low in the following cycle.
- R10: With no write, no operation and no compare, the status word is unchanged. A compare with a target above 10 changes no condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software load strobe |
| sw_wdata | input | 32 | Word to load |
| op_valid | input | 1 | An operation reports flags this cycle |
| op_flags | input | 5 | Raised exception flags |
| cmp_valid | input | 1 | A compare result is present |
| cmp_rel | input | 2 | Relation code: 0 gt, 1 lt, 2 eq, 3 unordered |
| cmp_mask | input | 5 | Condition mask; bit 0 selects signaling |
| cmp_target | input | 4 | 0 for queued compare, 1..10 for an addressed bit |
| status_o | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| assist_trap | output | 1 | Enabled-exception trap pulse |

## Verification
Every input applied in a cycle shows up in `status_o` and `assist_trap` after the next rising edge, and in no other cycle. `round_mode` and `flush_zero` follow the stored word with no further delay. The bench drives inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge against a reference word that it updates from the requirement rules. The sweeps cover every relation, every mask and every target 0..11, and all 32 flag patterns under changing enables.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int STAT_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int FLAG_LSB = 27;
  localparam int EN_LSB   = 0;
  localparam int FTZ_BIT  = 5;
  localparam int RM_LSB   = 9;
  localparam int RM_W     = 2;
  localparam int PRIM_BIT = 26;
  localparam int Q_TOP    = 21;
  localparam int Q_DEPTH  = 10;
  localparam int Q_LOW    = Q_TOP - Q_DEPTH;
  localparam int TGT_W    = $clog2(Q_DEPTH + 1);
  localparam int INV_IDX  = 4;

  typedef enum logic [1:0] {
    REL_GT    = 2'd0,
    REL_LT    = 2'd1,
    REL_EQ    = 2'd2,
    REL_UNORD = 2'd3
  } rel_e;
endpackage

// File: rtl/fpsr_flag_unit.sv
module fpsr_flag_unit
  import fpsr_pkg::*;
(
  input  logic              op_valid_i,
  input  logic [FLAG_W-1:0] op_flags_i,
  input  logic              cmp_valid_i,
  input  logic              cmp_signal_i,
  input  rel_e              cmp_rel_i,
  input  logic [FLAG_W-1:0] enables_i,
  output logic [FLAG_W-1:0] raised_o,
  output logic              trap_o
);
  logic sig_unord;

  always_comb begin
    sig_unord = cmp_valid_i && cmp_signal_i && (cmp_rel_i == REL_UNORD);
    raised_o  = op_valid_i ? op_flags_i : '0;
    raised_o[INV_IDX] = raised_o[INV_IDX] | sig_unord;
    trap_o    = |(raised_o & enables_i);
  end
endmodule

// File: rtl/fpsr_cmp_unit.sv
module fpsr_cmp_unit
  import fpsr_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic              cmp_valid_i,
  input  rel_e              cmp_rel_i,
  input  logic [FLAG_W-1:0] cmp_mask_i,
  input  logic [TGT_W-1:0]  cmp_target_i,
  output logic [STAT_W-1:0] stat_o
);
  logic               outcome;
  logic [Q_DEPTH-1:0] tgt_hit;

  for (genvar k = 0; k < Q_DEPTH; k++) begin : g_tgt
    assign tgt_hit[k] = (cmp_target_i == TGT_W'(k + 1));
  end

  always_comb begin
    unique case (cmp_rel_i)
      REL_GT:  outcome = cmp_mask_i[4];
      REL_LT:  outcome = cmp_mask_i[3];
      REL_EQ:  outcome = cmp_mask_i[2];
      default: outcome = cmp_mask_i[1];
    endcase
  end

  always_comb begin
    stat_o = stat_i;
    if (cmp_valid_i) begin
      if (cmp_target_i == '0) begin
        stat_o[Q_TOP-1:Q_LOW] = stat_i[Q_TOP:Q_LOW+1];
        stat_o[Q_TOP]         = stat_i[PRIM_BIT];
        stat_o[PRIM_BIT]      = outcome;
      end else begin
        for (int k = 0; k < Q_DEPTH; k++) begin
          if (tgt_hit[k]) stat_o[Q_TOP-k] = outcome;
        end
      end
    end
  end
endmodule

// File: rtl/fpsr_cq_top.sv
module fpsr_cq_top
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              op_valid,
  input  logic [FLAG_W-1:0] op_flags,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_rel,
  input  logic [FLAG_W-1:0] cmp_mask,
  input  logic [TGT_W-1:0]  cmp_target,
  output logic [STAT_W-1:0] status_o,
  output logic [RM_W-1:0]   round_mode,
  output logic              flush_zero,
  output logic              assist_trap
);
  logic [1:0]        rst_sync_q;
  logic              rst_ok;
  logic [STAT_W-1:0] stat_q, stat_d, stat_flag, stat_cmp;
  logic [FLAG_W-1:0] raised;
  logic              trap_d, trap_q, upd_en;
  rel_e              rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];
  assign rel    = rel_e'(cmp_rel);

  fpsr_flag_unit flag_i (
    .op_valid_i  (op_valid),
    .op_flags_i  (op_flags),
    .cmp_valid_i (cmp_valid),
    .cmp_signal_i(cmp_mask[0]),
    .cmp_rel_i   (rel),
    .enables_i   (stat_q[EN_LSB +: FLAG_W]),
    .raised_o    (raised),
    .trap_o      (trap_d)
  );

  always_comb begin
    stat_flag = stat_q;
    stat_flag[FLAG_LSB +: FLAG_W] = stat_q[FLAG_LSB +: FLAG_W] | raised;
  end

  fpsr_cmp_unit cmp_i (
    .stat_i      (stat_flag),
    .cmp_valid_i (cmp_valid),
    .cmp_rel_i   (rel),
    .cmp_mask_i  (cmp_mask),
    .cmp_target_i(cmp_target),
    .stat_o      (stat_cmp)
  );

  always_comb begin
    upd_en = sw_we || op_valid || cmp_valid;
    stat_d = sw_we ? sw_wdata : stat_cmp;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      stat_q <= '0;
      trap_q <= 1'b0;
    end else begin
      if (upd_en) stat_q <= stat_d;
      trap_q <= trap_d && !sw_we;
    end
  end

  assign status_o    = stat_q;
  assign round_mode  = stat_q[RM_LSB +: RM_W];
  assign flush_zero  = stat_q[FTZ_BIT];
  assign assist_trap = trap_q;

  // R9
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_we |=> (status_o == $past(sw_wdata)) && !assist_trap);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sw_we && op_valid) |=>
      ((status_o[FLAG_LSB +: FLAG_W] & $past(op_flags | status_o[FLAG_LSB +: FLAG_W]))
        == $past(op_flags | status_o[FLAG_LSB +: FLAG_W])));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sw_we && !op_valid && !cmp_valid) |=> $stable(status_o) && !assist_trap);
  // R7
  queue_shift_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sw_we && cmp_valid && cmp_target == '0) |=>
      (status_o[Q_TOP-1:Q_LOW] == $past(status_o[Q_TOP:Q_LOW+1])) &&
      (status_o[Q_TOP] == $past(status_o[PRIM_BIT])));
  // R4
  trap_source_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    assist_trap |-> $past(op_valid || cmp_valid) && !$past(sw_we));
endmodule

// File: tb/fpsr_cq_top_tb_top.sv
module fpsr_cq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_rel = '0;
  logic [4:0]  cmp_mask = '0;
  logic [3:0]  cmp_target = '0;
  logic [31:0] status_o;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        assist_trap;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_s = '0;
  logic        exp_t = 1'b0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #2 clk = ~clk;

  fpsr_cq_top dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // drive one cycle at the falling edge, update model, check at next falling edge
  task automatic step(string req, logic we, logic [31:0] wd, logic ov, logic [4:0] fl,
                      logic cv, logic [1:0] rl, logic [4:0] mk, logic [3:0] tg);
    logic [4:0]  raised;
    logic [31:0] n;
    logic        c;
    sw_we = we; sw_wdata = wd; op_valid = ov; op_flags = fl;
    cmp_valid = cv; cmp_rel = rl; cmp_mask = mk; cmp_target = tg;
    if (we) begin
      exp_s = wd; exp_t = 1'b0;
    end else begin
      raised = ov ? fl : 5'd0;
      if (cv && mk[0] && rl == 2'd3) raised[4] = 1'b1;   // R8
      exp_t = |(raised & exp_s[4:0]);
      exp_s[31:27] = exp_s[31:27] | raised;
      if (cv) begin
        c = (rl == 2'd0) ? mk[4] : (rl == 2'd1) ? mk[3] : (rl == 2'd2) ? mk[2] : mk[1];
        if (tg == 4'd0) begin
          n = exp_s;
          n[20:11] = exp_s[21:12];
          n[21] = exp_s[26];
          n[26] = c;
          exp_s = n;
        end else if (tg <= 4'd10) begin
          exp_s[22 - int'(tg)] = c;
        end
      end
    end
    @(negedge clk);
    sw_we = 1'b0; op_valid = 1'b0; cmp_valid = 1'b0;
    chk(req, status_o, exp_s);
    chk({req, " trap"}, {31'd0, assist_trap}, {31'd0, exp_t});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", status_o, 32'd0);
    chk("R1 reset trap", {31'd0, assist_trap}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 released", status_o, 32'd0);
    chk("R10 idle", status_o, 32'd0);

    // R2 rounding and flush decode
    for (int m = 0; m < 8; m++) begin
      step("R9 load", 1'b1, 32'(m[1:0]) << 9 | 32'(m[2]) << 5, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 4'd0);
      chk("R2 round", {30'd0, round_mode}, 32'(m[1:0]));
      chk("R2 flush", {31'd0, flush_zero}, 32'(m[2]));
    end

    // R3 / R4 flag sweep under varying enables
    for (int e = 0; e < 32; e += 5) begin
      for (int f = 0; f < 32; f++) begin
        step("R9 load", 1'b1, 32'(e), 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 4'd0);
        step("R3 R4 flags", 1'b0, 32'd0, 1'b1, 5'(f), 1'b0, 2'd0, 5'd0, 4'd0);
      end
    end

    // R5 R6 R7 R8 R10 compare sweep, target 11 leaves condition bits alone
    for (int r = 0; r < 4; r++) begin
      for (int mk = 0; mk < 32; mk++) begin
        for (int t = 0; t < 12; t++) begin
          lfsr = nxt(lfsr);
          step("R9 load", 1'b1, lfsr, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 4'd0);
          step("R5 R6 R7 R8 R10 compare", 1'b0, 32'd0, 1'b0, 5'd0, 1'b1, 2'(r), 5'(mk), 4'(t));
        end
      end
    end

    // R7 repeated queue pushes
    step("R9 load", 1'b1, 32'h0000_001F, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 4'd0);
    for (int i = 0; i < 14; i++)
      step("R7 queue", 1'b0, 32'd0, 1'b0, 5'd0, 1'b1, 2'(i % 4), 5'(i * 7), 4'd0);

    // R3 combined with a compare, then R9 priority over both
    step("R3 R8 combined", 1'b0, 32'd0, 1'b1, 5'b00011, 1'b1, 2'd3, 5'b00011, 4'd0);
    step("R9 priority", 1'b1, 32'hA5A5_0000, 1'b1, 5'b11111, 1'b1, 2'd3, 5'b11111, 4'd0);
    step("R10 idle", 1'b0, 32'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 4'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule